// File: doc/BRIEF.md
# Fetch-Stage Branch Direction and Target Predictor

This block sits beside the instruction fetch unit and guesses the next fetch address in the same cycle the current address is presented. It combines two structures. One is a direct-mapped table of 2-bit saturating counters that holds the direction history of each branch. The other is a small tagged target cache that remembers where taken branches went. Both are indexed by low-order word-address bits of the fetch PC. When the cache hits and the counter leans taken, fetch jumps straight to the stored target. Otherwise fetch falls through to PC+4.

Later in the pipeline, the stage that settles a branch drives the resolve port. It supplies the branch PC, the real outcome, the real target, and the next PC that fetch used for it. The block trains both structures from this port. In the same cycle it compares the real next PC with the one that was used, and raises a flush together with the corrected address when they differ.

Top module: `branch_predictor`

## Requirements
- R1: After reset every counter holds 01 and every target cache entry is invalid, so any fetch PC gives pred_hit_o=0, pred_taken_o=0 and pred_next_pc_o=PC+4.
- R2: The counter table is indexed by PC[CTR_IDX_W+1:2] and the target cache by PC[BTB_IDX_W+1:2]. The cache tag is PC[PC_W-1:BTB_IDX_W+2]. Branches with different indices never disturb each other's state.
- R3: Counter encoding is 00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken. A resolved taken branch increments the counter and a resolved not-taken branch decrements it, saturating at 11 and 00. The predicted direction is bit 1.
- R4: When the target cache hits and the counter predicts taken, pred_taken_o=1 and pred_next_pc_o equals the stored target.
- R5: When the cache misses or the counter predicts not-taken, pred_taken_o=0 and pred_next_pc_o=PC+4, modulo 2^PC_W.
- R6: A resolved taken branch writes its cache entry: valid, tag and target. A fetch PC whose tag differs from the stored tag misses, even if the counter predicts taken.
- R7: flush_o rises in the same cycle as res_valid_i whenever the real next PC (res_target_i if taken, else res_pc_i+4) differs from res_pred_npc_i. redirect_pc_o then carries the real next PC. Direction errors and wrong targets both cause a flush.
- R8: Updates from the resolve port become visible to lookups from the next cycle onward. A lookup in the same cycle as an update to the same entry sees the state before that update.
- R9: From strong taken, a single not-taken outcome leaves the prediction taken. A loop branch that is taken repeatedly therefore mispredicts only once per exit, and two consecutive not-taken outcomes flip the prediction.
- R10: A resolved not-taken branch leaves its cache entry unchanged: valid, tag and target are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fetch_pc_i | input | PC_W | Current fetch address |
| pred_hit_o | output | 1 | Target cache holds a valid entry with a matching tag |
| pred_taken_o | output | 1 | Fetch redirected to the stored target |
| pred_next_pc_o | output | PC_W | Predicted next fetch address |
| res_valid_i | input | 1 | A conditional branch resolves this cycle |
| res_pc_i | input | PC_W | Address of the resolving branch |
| res_taken_i | input | 1 | Real direction of the branch |
| res_target_i | input | PC_W | Real taken target of the branch |
| res_pred_npc_i | input | PC_W | Next PC that fetch used after the branch |
| flush_o | output | 1 | Misprediction; squash younger work |
| redirect_pc_o | output | PC_W | Correct next PC after the resolving branch |

## Verification
Fetch lookup and resolve update can land on the same table and cache entry in one cycle. The bench provokes this by resolving a branch while fetch presents that same branch's PC. In that cycle the prediction must still reflect the state before the update, and the flush must reflect the resolve inputs. The following cycle, with the resolve port idle, must then show the trained prediction. The same overlap is repeated with a cache tag alias, where a second branch steals the shared entry while the first one is fetched afterwards.

// File: rtl/bp_pkg.sv
package bp_pkg;

  localparam logic [1:0] CTR_SNT = 2'b00;
  localparam logic [1:0] CTR_WNT = 2'b01;
  localparam logic [1:0] CTR_WT  = 2'b10;
  localparam logic [1:0] CTR_ST  = 2'b11;

  function automatic logic [1:0] ctr_next(input logic [1:0] cur, input logic taken);
    logic [1:0] nxt;
    nxt = cur;
    if (taken && cur != CTR_ST)       nxt = cur + 2'd1;
    else if (!taken && cur != CTR_SNT) nxt = cur - 2'd1;
    return nxt;
  endfunction

endpackage

// File: rtl/bp_counter_table.sv
module bp_counter_table
  import bp_pkg::*;
#(
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_taken_o,
  input  logic             upd_en_i,
  input  logic [IDX_W-1:0] upd_idx_i,
  input  logic             upd_taken_i
);
  localparam int unsigned ENTRIES = 1 << IDX_W;

  logic [ENTRIES-1:0][1:0] ctr_q;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ctr
    logic [1:0] cell_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cell_q <= CTR_WNT;
      end else if (upd_en_i && upd_idx_i == IDX_W'(g)) begin
        cell_q <= ctr_next(cell_q, upd_taken_i);
      end
    end
    assign ctr_q[g] = cell_q;
  end

  assign rd_taken_o = ctr_q[rd_idx_i][1];

  assert_sat_hi_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_en_i && upd_taken_i && ctr_q[upd_idx_i] == CTR_ST
    |=> ctr_q[$past(upd_idx_i)] == CTR_ST);

  assert_sat_lo_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_en_i && !upd_taken_i && ctr_q[upd_idx_i] == CTR_SNT
    |=> ctr_q[$past(upd_idx_i)] == CTR_SNT);

  assert_step_up_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_en_i && upd_taken_i && ctr_q[upd_idx_i] != CTR_ST
    |=> ctr_q[$past(upd_idx_i)] == $past(ctr_q[upd_idx_i]) + 2'd1);

  assert_step_dn_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_en_i && !upd_taken_i && ctr_q[upd_idx_i] != CTR_SNT
    |=> ctr_q[$past(upd_idx_i)] == $past(ctr_q[upd_idx_i]) - 2'd1);

endmodule

// File: rtl/bp_target_cache.sv
module bp_target_cache #(
  parameter int unsigned IDX_W = 3,
  parameter int unsigned TAG_W = 27,
  parameter int unsigned TGT_W = 30
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic [TAG_W-1:0] rd_tag_i,
  output logic             hit_o,
  output logic [TGT_W-1:0] target_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic [TGT_W-1:0] wr_target_i
);
  localparam int unsigned ENTRIES = 1 << IDX_W;

  logic [ENTRIES-1:0]            valid_q;
  logic [ENTRIES-1:0][TAG_W-1:0] tag_q;
  logic [ENTRIES-1:0][TGT_W-1:0] tgt_q;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic             v_q;
    logic [TAG_W-1:0] t_q;
    logic [TGT_W-1:0] d_q;
    logic             sel;
    assign sel = wr_en_i && wr_idx_i == IDX_W'(g);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  v_q <= 1'b0;
      else if (sel) v_q <= 1'b1;
    end

    // payload needs no reset: gated by valid
    always_ff @(posedge clk_i) begin
      if (sel) begin
        t_q <= wr_tag_i;
        d_q <= wr_target_i;
      end
    end

    assign valid_q[g] = v_q;
    assign tag_q[g]   = t_q;
    assign tgt_q[g]   = d_q;
  end

  assign hit_o    = valid_q[rd_idx_i] && tag_q[rd_idx_i] == rd_tag_i;
  assign target_o = tgt_q[rd_idx_i];

  assert_fill_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> valid_q[$past(wr_idx_i)] && tag_q[$past(wr_idx_i)] == $past(wr_tag_i)
                && tgt_q[$past(wr_idx_i)] == $past(wr_target_i));

  assert_keep_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(valid_q) && $stable(tag_q) && $stable(tgt_q));

endmodule

// File: rtl/bp_resolve.sv
module bp_resolve #(
  parameter int unsigned PC_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            res_valid_i,
  input  logic [PC_W-1:0] res_pc_i,
  input  logic            res_taken_i,
  input  logic [PC_W-1:0] res_target_i,
  input  logic [PC_W-1:0] res_pred_npc_i,
  output logic            flush_o,
  output logic [PC_W-1:0] redirect_pc_o
);
  logic [PC_W-1:0] actual_npc;

  assign actual_npc    = res_taken_i ? res_target_i : res_pc_i + PC_W'(4);
  assign flush_o       = res_valid_i && actual_npc != res_pred_npc_i;
  assign redirect_pc_o = actual_npc;

  assert_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_i |-> !flush_o);

  assert_agree_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i && !flush_o |-> redirect_pc_o == res_pred_npc_i);

endmodule

// File: rtl/branch_predictor.sv
module branch_predictor #(
  parameter int unsigned PC_W      = 32,
  parameter int unsigned CTR_IDX_W = 4,
  parameter int unsigned BTB_IDX_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] fetch_pc_i,
  output logic            pred_hit_o,
  output logic            pred_taken_o,
  output logic [PC_W-1:0] pred_next_pc_o,
  input  logic            res_valid_i,
  input  logic [PC_W-1:0] res_pc_i,
  input  logic            res_taken_i,
  input  logic [PC_W-1:0] res_target_i,
  input  logic [PC_W-1:0] res_pred_npc_i,
  output logic            flush_o,
  output logic [PC_W-1:0] redirect_pc_o
);
  localparam int unsigned TAG_W = PC_W - BTB_IDX_W - 2;
  localparam int unsigned TGT_W = PC_W - 2;

  logic             dir_taken;
  logic             btb_hit;
  logic [TGT_W-1:0] btb_tgt;

  bp_counter_table #(.IDX_W(CTR_IDX_W)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (fetch_pc_i[CTR_IDX_W+1:2]),
    .rd_taken_o (dir_taken),
    .upd_en_i   (res_valid_i),
    .upd_idx_i  (res_pc_i[CTR_IDX_W+1:2]),
    .upd_taken_i(res_taken_i)
  );

  bp_target_cache #(.IDX_W(BTB_IDX_W), .TAG_W(TAG_W), .TGT_W(TGT_W)) u_btb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (fetch_pc_i[BTB_IDX_W+1:2]),
    .rd_tag_i   (fetch_pc_i[PC_W-1:BTB_IDX_W+2]),
    .hit_o      (btb_hit),
    .target_o   (btb_tgt),
    .wr_en_i    (res_valid_i && res_taken_i),
    .wr_idx_i   (res_pc_i[BTB_IDX_W+1:2]),
    .wr_tag_i   (res_pc_i[PC_W-1:BTB_IDX_W+2]),
    .wr_target_i(res_target_i[PC_W-1:2])
  );

  bp_resolve #(.PC_W(PC_W)) u_res (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .res_valid_i   (res_valid_i),
    .res_pc_i      (res_pc_i),
    .res_taken_i   (res_taken_i),
    .res_target_i  (res_target_i),
    .res_pred_npc_i(res_pred_npc_i),
    .flush_o       (flush_o),
    .redirect_pc_o (redirect_pc_o)
  );

  assign pred_hit_o     = btb_hit;
  assign pred_taken_o   = btb_hit && dir_taken;
  assign pred_next_pc_o = pred_taken_o ? {btb_tgt, 2'b00} : fetch_pc_i + PC_W'(4);

  assert_taken_hit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_taken_o |-> pred_hit_o);

  assert_fallthru_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pred_taken_o |-> pred_next_pc_o == fetch_pc_i + PC_W'(4));

  assert_redirect_word_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_taken_o |-> pred_next_pc_o[1:0] == 2'b00);

endmodule

// File: tb/sim_branch_predictor.sv
`timescale 1ns/1ps
module sim_branch_predictor;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        pred_hit, pred_taken, flush;
  logic [31:0] pred_npc, redirect;
  logic        res_valid = 1'b0;
  logic [31:0] res_pc = '0;
  logic        res_taken = 1'b0;
  logic [31:0] res_target = '0;
  logic [31:0] res_pred = '0;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  branch_predictor u0 (
    .clk_i(clk), .rst_ni(rst_ni), .fetch_pc_i(fetch_pc),
    .pred_hit_o(pred_hit), .pred_taken_o(pred_taken), .pred_next_pc_o(pred_npc),
    .res_valid_i(res_valid), .res_pc_i(res_pc), .res_taken_i(res_taken),
    .res_target_i(res_target), .res_pred_npc_i(res_pred),
    .flush_o(flush), .redirect_pc_o(redirect)
  );

  typedef struct packed {
    logic        rv;
    logic [31:0] rpc;
    logic        rtk;
    logic [31:0] rtgt;
    logic [31:0] rpred;
    logic [31:0] fpc;
    logic        xfl;
    logic [31:0] xred;
    logic        xtk;
    logic        xhit;
    logic [31:0] xnpc;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 19;
  // A=0x100 and B=0x200 share counter index 0 and cache index 0, tags differ
  localparam vec_t VEC [NV] = '{
    '{1'b0, 32'h0,   1'b0, 32'h0,   32'h0,   32'h100, 1'b0, 32'h0,   1'b0, 1'b0, 32'h104, 4'd1},  // R1
    '{1'b1, 32'h100, 1'b1, 32'h400, 32'h104, 32'h100, 1'b1, 32'h400, 1'b0, 1'b0, 32'h104, 4'd7},  // R7 R8 same-cycle
    '{1'b0, 32'h0,   1'b0, 32'h0,   32'h0,   32'h100, 1'b0, 32'h0,   1'b1, 1'b1, 32'h400, 4'd8},  // R8
    '{1'b1, 32'h100, 1'b1, 32'h400, 32'h400, 32'h100, 1'b0, 32'h0,   1'b1, 1'b1, 32'h400, 4'd4},  // R4
    '{1'b1, 32'h100, 1'b0, 32'h400, 32'h400, 32'h100, 1'b1, 32'h104, 1'b1, 1'b1, 32'h400, 4'd7},  // R7 loop exit
    '{1'b1, 32'h100, 1'b1, 32'h400, 32'h400, 32'h100, 1'b0, 32'h0,   1'b1, 1'b1, 32'h400, 4'd9},  // R9 re-entry
    '{1'b1, 32'h100, 1'b0, 32'h400, 32'h400, 32'h104, 1'b1, 32'h104, 1'b0, 1'b0, 32'h108, 4'd7},  // R7
    '{1'b1, 32'h100, 1'b0, 32'h400, 32'h400, 32'h100, 1'b1, 32'h104, 1'b1, 1'b1, 32'h400, 4'd9},  // R9
    '{1'b0, 32'h0,   1'b0, 32'h0,   32'h0,   32'h100, 1'b0, 32'h0,   1'b0, 1'b1, 32'h104, 4'd10}, // R10 flipped, entry kept
    '{1'b1, 32'h100, 1'b0, 32'h400, 32'h104, 32'h100, 1'b0, 32'h0,   1'b0, 1'b1, 32'h104, 4'd3},  // R3
    '{1'b1, 32'h100, 1'b0, 32'h400, 32'h104, 32'h100, 1'b0, 32'h0,   1'b0, 1'b1, 32'h104, 4'd3},  // R3 saturate low
    '{1'b1, 32'h100, 1'b1, 32'h400, 32'h104, 32'h100, 1'b1, 32'h400, 1'b0, 1'b1, 32'h104, 4'd7},  // R7
    '{1'b0, 32'h0,   1'b0, 32'h0,   32'h0,   32'h100, 1'b0, 32'h0,   1'b0, 1'b1, 32'h104, 4'd3},  // R3 00->01 only
    '{1'b1, 32'h200, 1'b1, 32'h800, 32'h204, 32'h200, 1'b1, 32'h800, 1'b0, 1'b0, 32'h204, 4'd6},  // R6 alias miss
    '{1'b0, 32'h0,   1'b0, 32'h0,   32'h0,   32'h100, 1'b0, 32'h0,   1'b0, 1'b0, 32'h104, 4'd6},  // R6 evicted
    '{1'b0, 32'h0,   1'b0, 32'h0,   32'h0,   32'h200, 1'b0, 32'h0,   1'b1, 1'b1, 32'h800, 4'd4},  // R4
    '{1'b0, 32'h0,   1'b0, 32'h0,   32'h0,   32'h104, 1'b0, 32'h0,   1'b0, 1'b0, 32'h108, 4'd2},  // R2 untouched index
    '{1'b1, 32'h200, 1'b1, 32'h900, 32'h800, 32'h200, 1'b1, 32'h900, 1'b1, 1'b1, 32'h800, 4'd7},  // R7 wrong target
    '{1'b0, 32'h0,   1'b0, 32'h0,   32'h0,   32'h200, 1'b0, 32'h0,   1'b1, 1'b1, 32'h900, 4'd4}   // R4 retargeted
  };

  task automatic chk(input string what, input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle_res();
    res_valid = 1'b0; res_pc = '0; res_taken = 1'b0; res_target = '0; res_pred = '0;
  endtask

  initial begin
    #40000;
    fails++;
    $display("FAIL R1 watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state before release
    fetch_pc = 32'h0000_0040;
    #1;
    chk("reset hit", 1, {31'b0, pred_hit}, 32'h0);
    chk("reset npc", 1, pred_npc, 32'h44);
    @(negedge clk);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      res_valid = VEC[i].rv; res_pc = VEC[i].rpc; res_taken = VEC[i].rtk;
      res_target = VEC[i].rtgt; res_pred = VEC[i].rpred; fetch_pc = VEC[i].fpc;
      #1;
      chk($sformatf("v%0d flush", i), int'(VEC[i].req), {31'b0, flush}, {31'b0, VEC[i].xfl});
      if (VEC[i].xfl)
        chk($sformatf("v%0d redirect", i), int'(VEC[i].req), redirect, VEC[i].xred);
      chk($sformatf("v%0d taken", i), int'(VEC[i].req), {31'b0, pred_taken}, {31'b0, VEC[i].xtk});
      chk($sformatf("v%0d hit", i), int'(VEC[i].req), {31'b0, pred_hit}, {31'b0, VEC[i].xhit});
      chk($sformatf("v%0d npc", i), int'(VEC[i].req), pred_npc, VEC[i].xnpc);
    end

    // R5 fall-through wraps at the top of the address space
    @(negedge clk);
    idle_res();
    fetch_pc = 32'hFFFF_FFFC;
    #1;
    chk("wrap npc", 5, pred_npc, 32'h0);

    // R1 mid-run reset clears trained state
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    fetch_pc = 32'h200;
    #1;
    chk("post-reset hit", 1, {31'b0, pred_hit}, 32'h0);
    chk("post-reset npc", 1, pred_npc, 32'h204);

    // R3 one taken from reset reaches weak taken and predicts taken
    @(negedge clk);
    res_valid = 1'b1; res_pc = 32'h10C; res_taken = 1'b1;
    res_target = 32'h700; res_pred = 32'h110; fetch_pc = 32'h10C;
    @(negedge clk);
    idle_res();
    #1;
    chk("weak taken dir", 3, {31'b0, pred_taken}, 32'h1);
    chk("weak taken npc", 3, pred_npc, 32'h700);

    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule